// File: doc/BRIEF.md
# Command-List Control Register Block

This block is the register front end of a display command processor. A host bus master reaches eight 32-bit word registers through a single-cycle request bus with valid, write, address, data and a per-bit write mask. Three registers hold command-list addresses: the list base, the list limit and the current fetch position. A status word mixes three host-controlled mode flags with eight flags reported by the command engine. Four saturating activity counters measure engine utilisation.

The host never writes the status flags directly. Instead, each mode flag has a dedicated clear command bit and set command bit, and further command bits zero the counters. Some writes also have side effects. Writing the list base also reloads the fetch position. Writing the list limit emits a one-cycle kick to the command parser. Clearing freeze emits a one-cycle resume request to the companion processor, but only when that processor is neither halted nor stopped at a break. Read data is registered, so it returns one cycle after the request.

Top module: `cmdlist_ctrl_regs`

## Requirements
- R1: A synchronous active-high reset clears all registers, mode flags and counters to zero and drives `rd_valid`, `dec_err`, `kick_proc` and `resume_cop` low.
- R2: A read with address bits [28:5] equal to the base and bits [1:0] zero returns, one cycle later with `rd_valid` high, the register selected by bits [4:2]. Offset 0x00 is list base, 0x04 list limit, 0x08 fetch position, 0x0C status, 0x10 clock counter, 0x14 buffer-busy counter, 0x18 pipe-busy counter and 0x1C texture-memory counter. Address bits [31:29] are ignored.
- R3: For any access outside that window, including a misaligned one, `dec_err` is high for one cycle after it and a read returns zero. A write there changes no register.
- R4: Every write takes effect with its data ANDed bit by bit with `req_wmask`. This includes status command bits.
- R5: A write to offset 0x00 loads the masked value into both list base and fetch position.
- R6: A write to offset 0x04 stores the masked value into the list limit and drives `kick_proc` high for exactly the following cycle.
- R7: Writes to offset 0x08 and to the counter offsets 0x10 to 0x1C change nothing.
- R8: A write to status applies command bits as clear-then-set pairs. Bits 0/1 clear/set the DMEM-source flag, bits 2/3 clear/set freeze, and bits 4/5 clear/set flush. When both bits of a pair are set, the flag ends up set.
- R9: Status reads back as follows. Bit 0 is DMEM-source, bit 1 freeze and bit 2 flush. Bits 3 to 10 are the inputs `in_gclk`, `in_tmem_busy`, `in_pipe_busy`, `in_cmd_busy`, `in_cbuf_ready`, `in_dma_busy`, `in_end_valid` and `in_start_valid`, in that order. All higher bits are zero.
- R10: A status write whose masked bit 2 is set drives `resume_cop` high for the following cycle only if `cop_halt` and `cop_broke` were both low during the write.
- R11: Each counter increments by one per clock edge while its condition holds. The clock counter counts while freeze is low. The buffer-busy counter counts on `in_cmd_busy`, the pipe-busy counter on `in_pipe_busy`, and the texture-memory counter on `in_tmem_busy`.
- R12: Status command bits 6, 7, 8 and 9 zero the texture-memory, pipe-busy, buffer-busy and clock counters respectively. A clear wins over an increment in the same cycle.
- R13: Counters saturate at all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | DATA_W | Write data |
| req_wmask | input | DATA_W | Per-bit write enable mask |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | DATA_W | Registered read data |
| dec_err | output | 1 | Access fell outside the register window |
| kick_proc | output | 1 | One-cycle start-processing pulse to the parser |
| resume_cop | output | 1 | One-cycle resume request to the companion processor |
| cop_halt | input | 1 | Companion processor is halted |
| cop_broke | input | 1 | Companion processor stopped at a break |
| in_gclk | input | 1 | Engine clock-started flag |
| in_tmem_busy | input | 1 | Texture memory busy |
| in_pipe_busy | input | 1 | Pipeline busy |
| in_cmd_busy | input | 1 | Command buffer busy |
| in_cbuf_ready | input | 1 | Command buffer ready |
| in_dma_busy | input | 1 | Command DMA busy |
| in_end_valid | input | 1 | Engine holds a valid list limit |
| in_start_valid | input | 1 | Engine holds a valid list base |

## Verification
The bench targets status pairs that carry both the clear and the set bit. A design that applied set before clear would report the flag cleared. A clear-counter command is issued on the same edge as a busy input, and a design letting the increment win would read back one instead of zero. An out-of-window write is aimed at an address whose low bits alias the list base, so a decoder that ignored the upper offset bits would corrupt that register. The resume request is tried with halt and with break raised one at a time, and with the clear-freeze bit masked off, to catch gating that forgets one condition or acts on unmasked data.

// File: rtl/cmdlist_ctrl_regs.sv
module cmdlist_ctrl_regs #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CNT_W     = 32,
  parameter logic [31:0] BASE_ADDR = 32'h0410_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [31:0]       req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] req_wmask,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              dec_err,
  output logic              kick_proc,
  output logic              resume_cop,
  input  logic              cop_halt,
  input  logic              cop_broke,
  input  logic              in_gclk,
  input  logic              in_tmem_busy,
  input  logic              in_pipe_busy,
  input  logic              in_cmd_busy,
  input  logic              in_cbuf_ready,
  input  logic              in_dma_busy,
  input  logic              in_end_valid,
  input  logic              in_start_valid
);
  localparam int unsigned NCNT = 4;

  logic              hit, wr, rd;
  logic [2:0]        off;
  logic [DATA_W-1:0] wval;
  logic              wr_base, wr_limit, wr_stat;
  logic [DATA_W-1:0] base_q, limit_q, cur_q;
  logic              dmem_q, frz_q, flush_q;
  logic [NCNT-1:0]   cnt_clr, cnt_inc;
  logic [CNT_W-1:0]  cnt_v [NCNT];
  logic [DATA_W-1:0] stat_word, rd_mux;
  logic              unused_bits;

  assign off      = req_addr[4:2];
  assign hit      = (req_addr[28:5] == BASE_ADDR[28:5]) && (req_addr[1:0] == 2'b00);
  assign wr       = req_valid & req_write & hit;
  assign rd       = req_valid & ~req_write;
  assign wval     = req_wdata & req_wmask;
  assign wr_base  = wr && (off == 3'd0);
  assign wr_limit = wr && (off == 3'd1);
  assign wr_stat  = wr && (off == 3'd3);
  assign unused_bits = ^req_addr[31:29];

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      limit_q <= '0;
      cur_q   <= '0;
    end else begin
      if (wr_base) begin
        base_q <= wval;
        cur_q  <= wval;
      end
      if (wr_limit) limit_q <= wval;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dmem_q  <= 1'b0;
      frz_q   <= 1'b0;
      flush_q <= 1'b0;
    end else if (wr_stat) begin
      dmem_q  <= (dmem_q  & ~wval[0]) | wval[1];
      frz_q   <= (frz_q   & ~wval[2]) | wval[3];
      flush_q <= (flush_q & ~wval[4]) | wval[5];
    end
  end

  assign cnt_clr = {NCNT{wr_stat}} & {wval[6], wval[7], wval[8], wval[9]};
  assign cnt_inc = {in_tmem_busy, in_pipe_busy, in_cmd_busy, ~frz_q};

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    logic [CNT_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst || cnt_clr[g])
        q <= '0;
      else if (cnt_inc[g] && (q != {CNT_W{1'b1}}))
        q <= q + CNT_W'(1);
    end
    assign cnt_v[g] = q;
  end

  always_comb begin
    stat_word = '0;
    stat_word[10:0] = {in_start_valid, in_end_valid, in_dma_busy, in_cbuf_ready,
                       in_cmd_busy, in_pipe_busy, in_tmem_busy, in_gclk,
                       flush_q, frz_q, dmem_q};
  end

  always_comb begin
    case (off)
      3'd0:    rd_mux = base_q;
      3'd1:    rd_mux = limit_q;
      3'd2:    rd_mux = cur_q;
      3'd3:    rd_mux = stat_word;
      3'd4:    rd_mux = DATA_W'(cnt_v[0]);
      3'd5:    rd_mux = DATA_W'(cnt_v[1]);
      3'd6:    rd_mux = DATA_W'(cnt_v[2]);
      default: rd_mux = DATA_W'(cnt_v[3]);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      dec_err    <= 1'b0;
      kick_proc  <= 1'b0;
      resume_cop <= 1'b0;
    end else begin
      rd_valid   <= rd;
      rd_data    <= (rd && hit) ? rd_mux : '0;
      dec_err    <= req_valid & ~hit;
      kick_proc  <= wr_limit;
      resume_cop <= wr_stat & wval[2] & ~cop_halt & ~cop_broke;
    end
  end
endmodule

module cmdlist_ctrl_regs_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              dec_err,
  input logic              kick_proc,
  input logic              resume_cop,
  input logic              cop_halt,
  input logic              cop_broke,
  input logic [DATA_W-1:0] cur_q,
  input logic              frz_q,
  input logic              wr_stat,
  input logic [DATA_W-1:0] wval,
  input logic [CNT_W-1:0]  clk_cnt
);
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rd_valid); // R2
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && dec_err) |-> (rd_data == '0)); // R3
  AST_KICK_CAUSE: assert property (@(posedge clk) disable iff (rst)
    kick_proc |-> $past(req_valid && req_write)); // R6
  AST_CUR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_write) |=> $stable(cur_q)); // R7
  AST_RESUME_GATE: assert property (@(posedge clk) disable iff (rst)
    resume_cop |-> $past(!cop_halt && !cop_broke && req_valid && req_write)); // R10
  AST_FREEZE_STOP: assert property (@(posedge clk) disable iff (rst)
    (frz_q && !wr_stat) |=> $stable(clk_cnt)); // R11
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
    ((clk_cnt == {CNT_W{1'b1}}) && !(wr_stat && wval[9])) |=> (clk_cnt == {CNT_W{1'b1}})); // R13
endmodule

bind cmdlist_ctrl_regs cmdlist_ctrl_regs_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .rd_valid(rd_valid), .rd_data(rd_data), .dec_err(dec_err),
  .kick_proc(kick_proc), .resume_cop(resume_cop),
  .cop_halt(cop_halt), .cop_broke(cop_broke),
  .cur_q(cur_q), .frz_q(frz_q), .wr_stat(wr_stat), .wval(wval),
  .clk_cnt(cnt_v[0])
);

// File: tb/cmdlist_ctrl_regs_tb.sv
module cmdlist_ctrl_regs_tb_top;
  localparam logic [31:0] BASE = 32'h0410_0000;
  localparam logic [31:0] O_BASE = 32'h00, O_LIM = 32'h04, O_CUR = 32'h08, O_STAT = 32'h0C;
  localparam logic [31:0] O_CLK = 32'h10, O_BUF = 32'h14, O_PIPE = 32'h18, O_TMEM = 32'h1C;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_write = 0;
  logic [31:0] req_addr = 0, req_wdata = 0, req_wmask = 0;
  logic rd_valid, dec_err, kick_proc, resume_cop;
  logic [31:0] rd_data;
  logic cop_halt = 0, cop_broke = 0;
  logic in_gclk = 0, in_tmem_busy = 0, in_pipe_busy = 0, in_cmd_busy = 0;
  logic in_cbuf_ready = 0, in_dma_busy = 0, in_end_valid = 0, in_start_valid = 0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cmdlist_ctrl_regs #(.DATA_W(32), .CNT_W(8), .BASE_ADDR(BASE)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_wmask(req_wmask),
    .rd_valid(rd_valid), .rd_data(rd_data), .dec_err(dec_err),
    .kick_proc(kick_proc), .resume_cop(resume_cop),
    .cop_halt(cop_halt), .cop_broke(cop_broke),
    .in_gclk(in_gclk), .in_tmem_busy(in_tmem_busy), .in_pipe_busy(in_pipe_busy),
    .in_cmd_busy(in_cmd_busy), .in_cbuf_ready(in_cbuf_ready), .in_dma_busy(in_dma_busy),
    .in_end_valid(in_end_valid), .in_start_valid(in_start_valid));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [31:0] addr, input logic [31:0] data,
                        input logic [31:0] mask = 32'hFFFF_FFFF);
    req_valid = 1; req_write = 1; req_addr = addr; req_wdata = data; req_wmask = mask;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic bus_rd(input logic [31:0] addr, output logic [31:0] data,
                        output logic err, output logic vld);
    req_valid = 1; req_write = 0; req_addr = addr;
    @(negedge clk);
    req_valid = 0;
    data = rd_data; err = dec_err; vld = rd_valid;
  endtask

  function automatic logic [31:0] rd_exp(input logic [31:0] d);
    return d;
  endfunction

  task automatic rd_check(input string req, input logic [31:0] off, input logic [31:0] exp);
    logic [31:0] d; logic e, v;
    bus_rd(BASE + off, d, e, v);
    check(req, d, exp);
    check(req, {30'd0, e, v}, 32'h1);
  endtask

  task automatic t_reset;
    check("R1 kick", {31'd0, kick_proc}, 0);
    check("R1 resume", {31'd0, resume_cop}, 0);
    check("R1 err", {31'd0, dec_err}, 0);
    rd_check("R1 base", O_BASE, 0);
    rd_check("R1 limit", O_LIM, 0);
    rd_check("R1 cur", O_CUR, 0);
    rd_check("R1 status", O_STAT, 0);
    rd_check("R1 buf", O_BUF, 0);
    rd_check("R1 pipe", O_PIPE, 0);
    rd_check("R1 tmem", O_TMEM, 0);
  endtask

  task automatic t_base_limit;
    bus_wr(BASE + O_BASE, 32'h0012_3450);
    check("R6 no kick on base", {31'd0, kick_proc}, 0);
    rd_check("R5 base", O_BASE, 32'h0012_3450);
    rd_check("R5 cur", O_CUR, 32'h0012_3450);
    bus_wr(BASE + O_LIM, 32'hABCD_0000);
    check("R6 kick", {31'd0, kick_proc}, 1);
    tick(1);
    check("R6 kick one cycle", {31'd0, kick_proc}, 0);
    rd_check("R6 limit", O_LIM, 32'hABCD_0000);
  endtask

  task automatic t_alias_window;
    logic [31:0] d; logic e, v;
    bus_rd((BASE | 32'hE000_0000) + O_LIM, d, e, v);
    check("R2 top bits ignored", d, 32'hABCD_0000);
    check("R2 no err", {31'd0, e}, 0);
    bus_rd(BASE + 32'h20, d, e, v);
    check("R3 outside data", d, 0);
    check("R3 outside err", {30'd0, e, v}, 32'h3);
    tick(1);
    check("R3 err one cycle", {31'd0, dec_err}, 0);
    bus_rd(BASE + 32'h6, d, e, v);
    check("R3 misaligned", {d[30:0], e}, 32'h1);
    bus_wr(BASE + 32'h40, 32'h0000_1234);
    check("R3 write err", {31'd0, dec_err}, 1);
    rd_check("R3 write ignored", O_BASE, 32'h0012_3450);
  endtask

  task automatic t_mask;
    bus_wr(BASE + O_BASE, 32'hFFFF_FFFF, 32'h0000_FF0F);
    rd_check("R4 base masked", O_BASE, 32'h0000_FF0F);
    rd_check("R4 cur masked", O_CUR, 32'h0000_FF0F);
    bus_wr(BASE + O_STAT, 32'h0000_0008, 32'h0000_0000);
    rd_check("R4 status masked", O_STAT, 0);
  endtask

  task automatic t_ignored;
    logic [31:0] d; logic e, v;
    bus_wr(BASE + O_CUR, 32'hDEAD_BEEF);
    rd_check("R7 cur write", O_CUR, 32'h0000_FF0F);
    bus_rd(BASE + O_BUF, d, e, v);
    bus_wr(BASE + O_BUF, 32'h0000_0055);
    rd_check("R7 counter write", O_BUF, d);
  endtask

  task automatic t_status_pairs;
    bus_wr(BASE + O_STAT, 32'h2);  rd_check("R8 dmem set", O_STAT, 32'h1);
    bus_wr(BASE + O_STAT, 32'h3);  rd_check("R8 dmem both", O_STAT, 32'h1);
    bus_wr(BASE + O_STAT, 32'h1);  rd_check("R8 dmem clr", O_STAT, 32'h0);
    bus_wr(BASE + O_STAT, 32'h8);  rd_check("R8 frz set", O_STAT, 32'h2);
    bus_wr(BASE + O_STAT, 32'hC);  rd_check("R8 frz both", O_STAT, 32'h2);
    bus_wr(BASE + O_STAT, 32'h4);  rd_check("R8 frz clr", O_STAT, 32'h0);
    bus_wr(BASE + O_STAT, 32'h20); rd_check("R8 flush set", O_STAT, 32'h4);
    bus_wr(BASE + O_STAT, 32'h30); rd_check("R8 flush both", O_STAT, 32'h4);
    bus_wr(BASE + O_STAT, 32'h10); rd_check("R8 flush clr", O_STAT, 32'h0);
  endtask

  task automatic t_status_layout;
    bus_wr(BASE + O_STAT, 32'h20);
    {in_start_valid, in_end_valid, in_dma_busy, in_cbuf_ready,
     in_cmd_busy, in_pipe_busy, in_tmem_busy, in_gclk} = 8'b1010_1010;
    rd_check("R9 layout A", O_STAT, 32'h0000_0554);
    {in_start_valid, in_end_valid, in_dma_busy, in_cbuf_ready,
     in_cmd_busy, in_pipe_busy, in_tmem_busy, in_gclk} = 8'b0101_0101;
    bus_wr(BASE + O_STAT, 32'h1A);
    rd_check("R9 layout B", O_STAT, 32'h0000_02AB);
    {in_start_valid, in_end_valid, in_dma_busy, in_cbuf_ready,
     in_cmd_busy, in_pipe_busy, in_tmem_busy, in_gclk} = 8'h00;
    bus_wr(BASE + O_STAT, 32'h15);
    rd_check("R9 cleared", O_STAT, 0);
  endtask

  task automatic t_resume;
    cop_halt = 1; bus_wr(BASE + O_STAT, 32'h4);
    check("R10 halted", {31'd0, resume_cop}, 0);
    cop_halt = 0; cop_broke = 1; bus_wr(BASE + O_STAT, 32'h4);
    check("R10 broke", {31'd0, resume_cop}, 0);
    cop_broke = 0; bus_wr(BASE + O_STAT, 32'h4);
    check("R10 resume", {31'd0, resume_cop}, 1);
    tick(1);
    check("R10 one cycle", {31'd0, resume_cop}, 0);
    bus_wr(BASE + O_STAT, 32'h4, 32'hFFFF_FFFB);
    check("R10 masked off", {31'd0, resume_cop}, 0);
    bus_wr(BASE + O_STAT, 32'h8);
    check("R10 set freeze only", {31'd0, resume_cop}, 0);
  endtask

  task automatic t_counters;
    bus_wr(BASE + O_STAT, 32'h208);
    tick(3);
    rd_check("R11 frozen clock", O_CLK, 0);
    bus_wr(BASE + O_STAT, 32'h4);
    tick(4);
    bus_wr(BASE + O_STAT, 32'h8);
    rd_check("R11 clock count", O_CLK, 5);
    bus_wr(BASE + O_STAT, 32'h40);
    in_tmem_busy = 1; tick(7); in_tmem_busy = 0;
    rd_check("R11 tmem count", O_TMEM, 7);
    bus_wr(BASE + O_STAT, 32'h100);
    in_cmd_busy = 1; tick(3); in_cmd_busy = 0;
    rd_check("R11 buf count", O_BUF, 3);
    in_pipe_busy = 1; tick(2);
    bus_wr(BASE + O_STAT, 32'h80);
    in_pipe_busy = 0;
    rd_check("R12 clear beats inc", O_PIPE, 0);
    bus_wr(BASE + O_STAT, 32'h140);
    rd_check("R12 tmem cleared", O_TMEM, 0);
    rd_check("R12 buf cleared", O_BUF, 0);
  endtask

  task automatic t_saturate;
    bus_wr(BASE + O_STAT, 32'h204);
    tick(300);
    rd_check("R13 clock sat", O_CLK, 32'hFF);
    in_tmem_busy = 1; tick(300); in_tmem_busy = 0;
    rd_check("R13 tmem sat", O_TMEM, 32'hFF);
    bus_wr(BASE + O_STAT, 32'h200);
    tick(2);
    rd_check("R12 clock cleared after sat", O_CLK, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_base_limit();
    t_alias_window();
    t_mask();
    t_ignored();
    t_status_pairs();
    t_status_layout();
    t_resume();
    t_counters();
    t_saturate();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule